// File: doc/BRIEF.md
# Edge/Level Interrupt Controller

This block gathers a set of asynchronous event lines into one status register and raises a single interrupt pin. Each status bit has its own trigger mode: rising edge, falling edge or level. The two bits of that mode are held in two separate registers. One register holds the high bit of every status bit's mode and the other holds the low bit. A mask register decides which status bits may reach the pin. A host reads status and programs the mask, the mode halves, an error mask and the pin drive style over a small register bus. A read of the status register clears the bits that were latched on an edge.

Status bit 0 comes from a composite receiver-error source. It is the OR of seven error flags, each gated by its own bit in an error-mask register. Every source line passes through a two-stage synchroniser before edge detection.

Each status bit is a small state machine with two states. In ST_IDLE the bit reads 0. In ST_PEND the bit reads 1. In edge mode the transition ST_IDLE→ST_PEND is taken on a detected edge. The transition ST_PEND→ST_IDLE is taken on a status read when no new edge arrives in the same cycle. In level mode the state is loaded from the synchronised source on every clock.

Top module: `irq_el_ctrl`

## Requirements
- R1: After reset every register reads 0, every status bit is in ST_IDLE, the pin output is 0 and the pin output enable is 1.
- R2: Register addresses are: 0 status (read only), 1 mask, 2 mode-high, 3 mode-low, 4 error mask (7 bits, in bits 6..0), 5 pin setup (2 bits, in bits 1..0). A written value reads back, and bits beyond a register's width read 0.
- R3: The mode of bit k is {mode-high[k], mode-low[k]}. In mode 00 a 0→1 change of the source sets status bit k after the third rising clock edge that follows the change. The bit stays set after the source falls.
- R4: In mode 01 a 1→0 change of the source sets the status bit with the same latency. A 0→1 change has no effect.
- R5: In mode 10 the status bit follows the source with a latency of three clocks, and a read does not clear it.
- R6: Mode 11 behaves exactly like mode 00.
- R7: A read of address 0 returns the current status. The same clock edge clears every edge-mode bit, except a bit whose edge is detected in that same cycle.
- R8: The pin is asserted when (status AND mask) is nonzero. A masked bit still shows in the status register.
- R9: Pin setup: 00 gives an active-high push-pull pin (output enable 1). 01 gives an active-low push-pull pin. 10 gives open drain: the data is held 0 and the output enable is 1 only while the interrupt is asserted. 11 behaves as 00.
- R10: Status bit 0 is the OR of the error flags ANDed with the error mask. Error flag bits are: 6 Q-subcode CRC, 5 channel-status CRC, 4 PLL unlock, 3 validity, 2 confidence, 1 bi-phase, 0 parity. A flag whose mask bit is 0 has no effect.
- R11: Status bit k, for k ≥ 1, is sourced from event input bit k-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_evt | input | NSRC-1 | Event sources for status bits NSRC-1..1 |
| err_flag | input | NERR | Individual receiver error flags |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of status clears edge bits) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | NSRC | Write data |
| bus_rdata | output | NSRC | Read data, valid in the cycle bus_rd is high |
| irq_pin | output | 1 | Interrupt pin data |
| irq_pin_oe | output | 1 | Interrupt pin output enable |

## Verification
A wrong internal state appears in two places. A status bit stuck in ST_PEND or ST_IDLE shows up in the status read-back at the first read after the third clock edge following a source change. Because the pin is combinational from status and mask, the same fault shows at the pin in that cycle. A mode decoded from the wrong register half shows as a status bit that fails to latch, or that latches on the opposite edge. A missing error-mask gate shows as status bit 0 set while its flag is masked. A wrong drive decode shows at irq_pin or irq_pin_oe on the clock edge right after the pin setup register is written.

// File: rtl/irq_el_pkg.sv
package irq_el_pkg;
    typedef enum logic [1:0] {
        TRIG_RISE  = 2'b00,
        TRIG_FALL  = 2'b01,
        TRIG_LEVEL = 2'b10,
        TRIG_RSVD  = 2'b11
    } trig_e;

    typedef enum logic [1:0] {
        DRV_HIGH = 2'b00,
        DRV_LOW  = 2'b01,
        DRV_OD   = 2'b10,
        DRV_RSVD = 2'b11
    } drive_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } bit_state_e;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
    localparam logic [ADDR_W-1:0] A_MASK   = 3'd1;
    localparam logic [ADDR_W-1:0] A_MODEHI = 3'd2;
    localparam logic [ADDR_W-1:0] A_MODELO = 3'd3;
    localparam logic [ADDR_W-1:0] A_ERRMSK = 3'd4;
    localparam logic [ADDR_W-1:0] A_PINCTL = 3'd5;
endpackage

// File: rtl/irq_el_sync.sv
module irq_el_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/irq_el_cell.sv
module irq_el_cell
    import irq_el_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  lvl,
    input  logic  prev,
    input  trig_e mode,
    input  logic  clr,
    output logic  pend
);
    bit_state_e st_q, st_nx;
    logic       hit;

    always_comb begin
        unique case (mode)
            TRIG_FALL:  hit = prev & ~lvl;
            TRIG_LEVEL: hit = 1'b0;
            default:    hit = lvl & ~prev;
        endcase
    end

    always_comb begin
        st_nx = st_q;
        if (mode == TRIG_LEVEL) begin
            st_nx = lvl ? ST_PEND : ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: if (hit) st_nx = ST_PEND;
                ST_PEND: if (clr && !hit) st_nx = ST_IDLE;
                default: st_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    always_comb begin
        pend = (st_q == ST_PEND);
    end

    a_r3_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != TRIG_LEVEL && pend && !clr) |=> pend);
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != TRIG_LEVEL && clr && !hit) |=> !pend);
    a_r5_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TRIG_LEVEL) |=> (pend == $past(lvl)));
endmodule

// File: rtl/irq_el_drive.sv
module irq_el_drive
    import irq_el_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   any_irq,
    input  drive_e drv,
    output logic   pin,
    output logic   pin_oe
);
    always_comb begin
        unique case (drv)
            DRV_LOW: begin pin = ~any_irq; pin_oe = 1'b1;    end
            DRV_OD:  begin pin = 1'b0;     pin_oe = any_irq; end
            default: begin pin = any_irq;  pin_oe = 1'b1;    end
        endcase
    end

    a_r9_od_data_low: assert property (@(posedge clk) disable iff (!rst_n)
        (drv == DRV_OD) |-> (!pin && (pin_oe == any_irq)));
    a_r9_push_pull_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (drv != DRV_OD) |-> pin_oe);
endmodule

// File: rtl/irq_el_ctrl.sv
module irq_el_ctrl
    import irq_el_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int NERR = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-2:0]   src_evt,
    input  logic [NERR-1:0]   err_flag,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NSRC-1:0]   bus_wdata,
    output logic [NSRC-1:0]   bus_rdata,
    output logic              irq_pin,
    output logic              irq_pin_oe
);
    localparam int NSYNC = NSRC - 1 + NERR;

    logic [NSRC-1:0] mask_q, modehi_q, modelo_q;
    logic [NERR-1:0] errmask_q;
    drive_e          drv_q;

    logic [NSYNC-1:0] raw_in, sync_out;
    logic [NSRC-1:0]  lvl, prev_q, status;
    logic [NERR-1:0]  err_sync;
    logic             err_comp, clr_stat, any_irq;

    assign raw_in = {err_flag, src_evt};

    irq_el_sync #(.W(NSYNC), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (sync_out)
    );

    assign err_sync = sync_out[NSYNC-1 -: NERR];
    assign err_comp = |(err_sync & errmask_q);
    assign lvl      = {sync_out[NSRC-2:0], err_comp};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q    <= '0;
            modehi_q  <= '0;
            modelo_q  <= '0;
            errmask_q <= '0;
            drv_q     <= DRV_HIGH;
        end else if (bus_wr) begin
            unique case (bus_addr)
                A_MASK:   mask_q    <= bus_wdata;
                A_MODEHI: modehi_q  <= bus_wdata;
                A_MODELO: modelo_q  <= bus_wdata;
                A_ERRMSK: errmask_q <= bus_wdata[NERR-1:0];
                A_PINCTL: drv_q     <= drive_e'(bus_wdata[1:0]);
                default:  ;
            endcase
        end
    end

    assign clr_stat = bus_rd && (bus_addr == A_STATUS);

    for (genvar k = 0; k < NSRC; k++) begin : g_cell
        irq_el_cell u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .lvl  (lvl[k]),
            .prev (prev_q[k]),
            .mode (trig_e'({modehi_q[k], modelo_q[k]})),
            .clr  (clr_stat),
            .pend (status[k])
        );
    end

    assign any_irq = |(status & mask_q);

    irq_el_drive u_drive (
        .clk    (clk),
        .rst_n  (rst_n),
        .any_irq(any_irq),
        .drv    (drv_q),
        .pin    (irq_pin),
        .pin_oe (irq_pin_oe)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_STATUS: bus_rdata = status;
            A_MASK:   bus_rdata = mask_q;
            A_MODEHI: bus_rdata = modehi_q;
            A_MODELO: bus_rdata = modelo_q;
            A_ERRMSK: bus_rdata[NERR-1:0] = errmask_q;
            A_PINCTL: bus_rdata[1:0] = drv_q;
            default:  bus_rdata = '0;
        endcase
    end

    a_r8_pin_high_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_q == DRV_HIGH && (status & mask_q) != '0) |-> irq_pin);
    a_r10_masked_errors_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (errmask_q == '0 && modehi_q[0] == 1'b1 && modelo_q[0] == 1'b0) |=> !status[0]);
endmodule

// File: tb/irq_el_ctrl_tb.sv
`timescale 1ns/1ps
module irq_el_ctrl_tb;
    localparam int NSRC = 8;
    localparam int NERR = 7;

    logic            clk = 0;
    logic            rst_n = 0;
    logic [NSRC-2:0] src_evt = '0;
    logic [NERR-1:0] err_flag = '0;
    logic            bus_wr = 0, bus_rd = 0;
    logic [2:0]      bus_addr = '0;
    logic [NSRC-1:0] bus_wdata = '0;
    logic [NSRC-1:0] bus_rdata;
    logic            irq_pin, irq_pin_oe;

    always #2 clk = ~clk;

    irq_el_ctrl #(.NSRC(NSRC), .NERR(NERR)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .err_flag(err_flag),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_pin(irq_pin), .irq_pin_oe(irq_pin_oe)
    );

    typedef struct {
        int          kind;
        string       tag;
        logic [7:0]  exp;
    } item_t;

    item_t q[$];
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = q.pop_front();
            case (it.kind)
                0: act = bus_rdata;
                1: act = {7'b0, irq_pin};
                default: act = {7'b0, irq_pin_oe};
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        item_t it;
        bus_rd = 1; bus_addr = a;
        it.kind = 0; it.tag = tag; it.exp = e;
        q.push_back(it);
        @(posedge clk); #1;
        bus_rd = 0;
    endtask

    task automatic pin_chk(input logic p, input logic oe, input string tag);
        item_t it;
        it.kind = 1; it.tag = {tag, " pin"}; it.exp = {7'b0, p};
        q.push_back(it);
        it.kind = 2; it.tag = {tag, " oe"}; it.exp = {7'b0, oe};
        q.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk); #1;

        // R1 reset state
        for (int a = 0; a < 6; a++) rd(3'(a), 8'h00, "R1 reset reg");
        pin_chk(1'b0, 1'b1, "R1 reset");

        // R2 register map
        wr(3'd1, 8'hA5); rd(3'd1, 8'hA5, "R2 mask");
        wr(3'd2, 8'h3C); rd(3'd2, 8'h3C, "R2 modehi");
        wr(3'd3, 8'h0F); rd(3'd3, 8'h0F, "R2 modelo");
        wr(3'd4, 8'hFF); rd(3'd4, 8'h7F, "R2 errmask width");
        wr(3'd5, 8'hFE); rd(3'd5, 8'h02, "R2 pinctl width");
        wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        wr(3'd4, 8'h00); wr(3'd5, 8'h00);
        rd(3'd0, 8'h00, "R2 status clean");

        // R3 / R11 rising edge on bit1 from src_evt[0]
        wr(3'd1, 8'h02);
        src_evt[0] = 1; settle();
        pin_chk(1'b1, 1'b1, "R8 pin on masked status");
        rd(3'd0, 8'h02, "R3 rise latch");
        rd(3'd0, 8'h00, "R7 read cleared");
        src_evt[0] = 0; settle();
        rd(3'd0, 8'h00, "R3 fall ignored in rise mode");

        // R4 falling edge on bit2
        wr(3'd3, 8'h04);
        src_evt[1] = 1; settle();
        rd(3'd0, 8'h00, "R4 rise ignored");
        src_evt[1] = 0; settle();
        rd(3'd0, 8'h04, "R4 fall latch");
        rd(3'd0, 8'h00, "R4 cleared");

        // R5 level on bit3
        wr(3'd2, 8'h08);
        src_evt[2] = 1; settle();
        rd(3'd0, 8'h08, "R5 level high");
        rd(3'd0, 8'h08, "R5 read does not clear");
        src_evt[2] = 0; settle();
        rd(3'd0, 8'h00, "R5 level low");

        // R6 reserved mode on bit4
        wr(3'd2, 8'h18); wr(3'd3, 8'h14);
        src_evt[3] = 1; settle();
        rd(3'd0, 8'h10, "R6 mode11 rise latch");
        rd(3'd0, 8'h00, "R6 mode11 cleared");
        src_evt[3] = 0; settle();
        rd(3'd0, 8'h00, "R6 mode11 fall ignored");

        // R8 masked bit5 still visible in status
        src_evt[4] = 1; settle();
        pin_chk(1'b0, 1'b1, "R8 masked no pin");
        rd(3'd0, 8'h20, "R8 masked status visible");

        // R9 drive styles, bit3 level asserted
        wr(3'd1, 8'h08);
        src_evt[2] = 1; settle();
        pin_chk(1'b1, 1'b1, "R9 active high on");
        wr(3'd5, 8'h01); pin_chk(1'b0, 1'b1, "R9 active low on");
        wr(3'd5, 8'h02); pin_chk(1'b0, 1'b1, "R9 open drain on");
        wr(3'd5, 8'h03); pin_chk(1'b1, 1'b1, "R9 reserved on");
        src_evt[2] = 0; settle();
        pin_chk(1'b0, 1'b1, "R9 reserved off");
        wr(3'd5, 8'h01); pin_chk(1'b1, 1'b1, "R9 active low off");
        wr(3'd5, 8'h02); pin_chk(1'b0, 1'b0, "R9 open drain off");
        wr(3'd5, 8'h00);

        // R10 composite receiver error on bit0 (rise mode)
        wr(3'd1, 8'h01);
        err_flag = 7'h10; settle();
        rd(3'd0, 8'h00, "R10 masked unlock flag");
        wr(3'd4, 8'h10); settle();
        rd(3'd0, 8'h01, "R10 unlock enabled");
        rd(3'd0, 8'h00, "R10 cleared");
        err_flag = 7'h00; settle();
        wr(3'd4, 8'h41);
        err_flag = 7'h01; settle();
        pin_chk(1'b1, 1'b1, "R10 parity pin");
        rd(3'd0, 8'h01, "R10 parity latch");

        @(negedge clk); #1;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule